// File: doc/BRIEF.md
# Masked Even-Lane Signed Doubleword Multiplier

This block is a SIMD execution unit for a 512-bit vector datapath. The vector is split into 64-bit lanes. In each lane the unit takes the low 32-bit half of both sources, treats the two halves as signed numbers, and writes their full 64-bit product into that lane of the result. The high half of every source lane plays no part in the computation.

Three operating styles are supported. The legacy two-operand style works on 128 bits and passes the rest of the old destination through unchanged. The plain three-operand style works on 128 or 256 bits and clears everything above that length. The masked style works on 128, 256 or 512 bits. In that style an 8-bit lane mask chooses, lane by lane, whether a lane takes the product or is merged from the old destination or zeroed. The masked style can also take a single 32-bit second factor from a memory operand and use it in every lane. If an operation names a combination of style and length that the unit does not support, it produces an all-zero result.

The unit has two pipeline stages. It accepts one operation per cycle, and each result appears on the output exactly two cycles after its operation was accepted, flagged by `out_valid`.

Top module: `evenlane_mul_unit`

## Requirements
- R1: Result lane j (bits [64j+63:64j]) is the product of `src_a[64j+31:64j]` and `src_b[64j+31:64j]`, both read as signed 32-bit values. Bits [64j+63:64j+32] of either source have no effect on the result.
- R2: The product is a full 64-bit two's-complement value with no saturation. For example, 0x80000000 times 0x80000000 gives 0x4000000000000000, and 0xFFFFFFFF times 0x00000001 gives 0xFFFFFFFFFFFFFFFF.
- R3: In the masked style (`style`=2), `vlen` 0, 1 and 2 give 2, 4 and 8 active lanes. Every result lane at or above the active count is zero.
- R4: In the masked style with `mask_en`=1, an active lane j whose `lane_mask[j]` is 0 takes one of two values. With `zero_mode`=1 it is zero. With `zero_mode`=0 it equals the same lane of `old_dst`. With `mask_en`=0, every active lane takes its product and `lane_mask` has no effect.
- R5: In the masked style with both `bcast_en`=1 and `b_from_mem`=1, `src_b[31:0]` is the second factor in every lane. If either of these inputs is 0, or in any other style, each lane uses its own `src_b` low half.
- R6: In the plain style (`style`=1), `vlen` 0 and 1 give 2 and 4 active lanes. All active lanes take their products whatever `lane_mask`, `mask_en`, `zero_mode` and `bcast_en` say, and all higher lanes are zero.
- R7: In the legacy style (`style`=0) with `vlen`=0, lanes 0 and 1 take products of `src_a` and `src_b`, and result bits [511:128] equal `old_dst[511:128]`.
- R8: The following combinations give an all-zero result: `style`=3, `vlen`=3, the legacy style with `vlen` other than 0, and the plain style with `vlen`=2.
- R9: An operation accepted with `in_valid`=1 at a clock edge appears with `out_valid`=1 after exactly two more edges. Back-to-back operations are accepted every cycle and come out in order. Without an input, `out_valid` is 0.
- R10: A synchronous active-high `rst` clears `out_valid`, and also discards any operation still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| src_a | input | 512 | First source vector (also the destination in the legacy style) |
| src_b | input | 512 | Second source vector |
| old_dst | input | 512 | Prior destination value, used for merging and pass-through |
| lane_mask | input | 8 | Per-lane write mask, bit j for lane j |
| style | input | 2 | 0 legacy, 1 plain three-operand, 2 masked, 3 reserved |
| vlen | input | 2 | 0 = 128, 1 = 256, 2 = 512 bits, 3 reserved |
| mask_en | input | 1 | Apply `lane_mask` (masked style only) |
| zero_mode | input | 1 | Masked-off lanes are zeroed (1) or merged (0) |
| bcast_en | input | 1 | Broadcast request |
| b_from_mem | input | 1 | Second source comes from memory |
| out_valid | output | 1 | Result valid this cycle |
| result | output | 512 | Result vector |

## Verification
A wrong lane-select code in the first stage shows up as a single 64-bit lane of `result` holding a product, old data or zero where another of those was due. It is visible on the cycle that operation leaves the pipeline, two edges after it was issued. A fault in the valid pipeline shows either as a result whose issue-to-output distance is not two, or as an `out_valid` that has no expected operation behind it. That includes the cycle right after a reset taken mid-flight. Because each output is compared against its own issued operation, a lost or duplicated slot is caught at the first misaligned result.

// File: rtl/evm_pkg.sv
package evm_pkg;
  localparam int HALF_W = 32;
  localparam int LANE_W = 2 * HALF_W;

  typedef enum logic [1:0] {
    ST_LEGACY = 2'd0,
    ST_PLAIN  = 2'd1,
    ST_MASKED = 2'd2,
    ST_RSVD   = 2'd3
  } style_e;

  localparam logic [1:0] SEL_ZERO = 2'd0;
  localparam logic [1:0] SEL_PROD = 2'd1;
  localparam logic [1:0] SEL_KEEP = 2'd2;

  // signed half x signed half -> full-width lane product, wraps modulo 2^LANE_W
  function automatic logic [LANE_W-1:0] smul_half(input logic [HALF_W-1:0] x,
                                                  input logic [HALF_W-1:0] y);
    logic signed [LANE_W-1:0] xe;
    logic signed [LANE_W-1:0] ye;
    xe = {{HALF_W{x[HALF_W-1]}}, x};
    ye = {{HALF_W{y[HALF_W-1]}}, y};
    return LANE_W'(xe * ye);
  endfunction

  // active lane count for a length code: 128 << code bits
  function automatic int unsigned vlen_lanes(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic combo_ok(input style_e st, input logic [1:0] code);
    case (st)
      ST_LEGACY: return code == 2'd0;
      ST_PLAIN:  return code <= 2'd1;
      ST_MASKED: return code <= 2'd2;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/evm_lane_ctrl.sv
module evm_lane_ctrl
  import evm_pkg::*;
#(
  parameter int NL = 8
) (
  input  logic [1:0]          style,
  input  logic [1:0]          vlen,
  input  logic [NL-1:0]       lane_mask,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic                bcast_en,
  input  logic                b_from_mem,
  output logic [NL-1:0][1:0]  sel,
  output logic                use_bcast,
  output logic                combo_bad
);
  style_e      st;
  int unsigned nact;

  assign st        = style_e'(style);
  assign nact      = vlen_lanes(vlen);
  assign combo_bad = !combo_ok(st, vlen);
  assign use_bcast = (st == ST_MASKED) && bcast_en && b_from_mem && !combo_bad;

  for (genvar g = 0; g < NL; g++) begin : g_sel
    localparam int unsigned LANE_IDX = g;
    logic [1:0] sel_g;
    always_comb begin
      if (combo_bad)
        sel_g = SEL_ZERO;
      else if (LANE_IDX >= nact)
        sel_g = (st == ST_LEGACY) ? SEL_KEEP : SEL_ZERO;
      else if (st == ST_MASKED && mask_en && !lane_mask[g])
        sel_g = zero_mode ? SEL_ZERO : SEL_KEEP;
      else
        sel_g = SEL_PROD;
    end
    assign sel[g] = sel_g;
  end
endmodule

// File: rtl/evm_lane_mul.sv
module evm_lane_mul
  import evm_pkg::*;
(
  input  logic [LANE_W-1:0] a_lane,
  input  logic [LANE_W-1:0] b_lane,
  input  logic [HALF_W-1:0] b_scalar,
  input  logic              use_bcast,
  output logic [LANE_W-1:0] prod
);
  logic [HALF_W-1:0] b_fac;
  assign b_fac = use_bcast ? b_scalar : b_lane[HALF_W-1:0];
  assign prod  = smul_half(a_lane[HALF_W-1:0], b_fac);
endmodule

// File: rtl/evm_lane_merge.sv
module evm_lane_merge
  import evm_pkg::*;
(
  input  logic [LANE_W-1:0] prod,
  input  logic [LANE_W-1:0] old_lane,
  input  logic [1:0]        sel,
  output logic [LANE_W-1:0] lane_out
);
  always_comb begin
    case (sel)
      SEL_PROD: lane_out = prod;
      SEL_KEEP: lane_out = old_lane;
      default:  lane_out = '0;
    endcase
  end
endmodule

// File: rtl/evenlane_mul_unit.sv
module evenlane_mul_unit
  import evm_pkg::*;
#(
  parameter int DATA_W = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          src_a,
  input  logic [DATA_W-1:0]          src_b,
  input  logic [DATA_W-1:0]          old_dst,
  input  logic [DATA_W/LANE_W-1:0]   lane_mask,
  input  logic [1:0]                 style,
  input  logic [1:0]                 vlen,
  input  logic                       mask_en,
  input  logic                       zero_mode,
  input  logic                       bcast_en,
  input  logic                       b_from_mem,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          result
);
  localparam int NL = DATA_W / LANE_W;

  logic [NL-1:0][1:0] sel_d;
  logic               use_bcast;
  logic               combo_bad;
  logic [DATA_W-1:0]  prod_d;
  logic [DATA_W-1:0]  merged;

  logic               s1_valid;
  logic [DATA_W-1:0]  s1_prod;
  logic [DATA_W-1:0]  s1_old;
  logic [NL-1:0][1:0] s1_sel;

  evm_lane_ctrl #(.NL(NL)) u_ctrl (
    .style      (style),
    .vlen       (vlen),
    .lane_mask  (lane_mask),
    .mask_en    (mask_en),
    .zero_mode  (zero_mode),
    .bcast_en   (bcast_en),
    .b_from_mem (b_from_mem),
    .sel        (sel_d),
    .use_bcast  (use_bcast),
    .combo_bad  (combo_bad)
  );

  for (genvar g = 0; g < NL; g++) begin : g_mul
    evm_lane_mul u_mul (
      .a_lane    (src_a[g*LANE_W +: LANE_W]),
      .b_lane    (src_b[g*LANE_W +: LANE_W]),
      .b_scalar  (src_b[HALF_W-1:0]),
      .use_bcast (use_bcast),
      .prod      (prod_d[g*LANE_W +: LANE_W])
    );
  end

  // stage 1: products, lane-select codes and old destination
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_old   <= '0;
      s1_sel   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_prod  <= prod_d;
      s1_old   <= old_dst;
      s1_sel   <= sel_d;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_merge
    evm_lane_merge u_merge (
      .prod     (s1_prod[g*LANE_W +: LANE_W]),
      .old_lane (s1_old[g*LANE_W +: LANE_W]),
      .sel      (s1_sel[g]),
      .lane_out (merged[g*LANE_W +: LANE_W])
    );
  end

  // stage 2: final result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_valid;
      result    <= merged;
    end
  end

  logic unused_bad;
  assign unused_bad = combo_bad;
endmodule

// File: rtl/evm_checker.sv
module evm_checker #(
  parameter int DATA_W = 512,
  parameter int NL     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              s1_valid,
  input logic              out_valid,
  input logic [1:0]        style,
  input logic [1:0]        vlen,
  input logic              mask_en,
  input logic              zero_mode,
  input logic [NL-1:0]     lane_mask,
  input logic [DATA_W-1:0] old_dst,
  input logic [DATA_W-1:0] result
);
  // R9: accepted operation reaches stage 1 on the next edge
  a_r9_stage1_fill: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);

  // R9: stage 1 content reaches the output on the next edge, and nothing else does
  a_r9_out_follows: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);
  a_r9_no_phantom: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid);

  // R10: reset empties the output
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R8: reserved style yields all zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(style, 2) == 2'd3) |-> (result == '0));

  // R7: legacy style passes upper bits of the old destination
  a_r7_legacy_upper: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(style, 2) == 2'd0 && $past(vlen, 2) == 2'd0)
      |-> (result[DATA_W-1:128] == $past(old_dst[DATA_W-1:128], 2)));

  // R3: masked style at 128 bits clears everything above
  a_r3_tail_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(style, 2) == 2'd2 && $past(vlen, 2) == 2'd0)
      |-> (result[DATA_W-1:128] == '0));

  // R4: zeroing of masked-off lane 0
  a_r4_zero_lane0: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(style, 2) == 2'd2 && $past(vlen, 2) != 2'd3 &&
     $past(mask_en, 2) && $past(zero_mode, 2) && !$past(lane_mask[0], 2))
      |-> (result[63:0] == '0));
endmodule

bind evenlane_mul_unit evm_checker #(.DATA_W(DATA_W), .NL(NL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .s1_valid  (s1_valid),
  .out_valid (out_valid),
  .style     (style),
  .vlen      (vlen),
  .mask_en   (mask_en),
  .zero_mode (zero_mode),
  .lane_mask (lane_mask),
  .old_dst   (old_dst),
  .result    (result)
);

// File: tb/sim_evenlane_mul_unit.sv
module sim_evenlane_mul_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [511:0] src_a = '0, src_b = '0, old_dst = '0;
  logic [7:0]   lane_mask = '0;
  logic [1:0]   style = '0, vlen = '0;
  logic         mask_en = 1'b0, zero_mode = 1'b0, bcast_en = 1'b0, b_from_mem = 1'b0;
  logic         out_valid;
  logic [511:0] result;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [511:0] exp_q[$];
  string        tag_q[$];
  int           cyc_q[$];

  evenlane_mul_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .old_dst(old_dst), .lane_mask(lane_mask), .style(style), .vlen(vlen),
    .mask_en(mask_en), .zero_mode(zero_mode), .bcast_en(bcast_en),
    .b_from_mem(b_from_mem), .out_valid(out_valid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model written from the requirements
  function automatic logic [511:0] model(input logic [511:0] a, b, old, input logic [7:0] m,
                                         input logic [1:0] st, vl, input bit me, zm, bc, bm);
    logic [511:0] r;
    bit ok;
    int n;
    r = '0;
    case (st)
      2'd0: ok = (vl == 2'd0);
      2'd1: ok = (vl <= 2'd1);
      2'd2: ok = (vl <= 2'd2);
      default: ok = 1'b0;
    endcase
    if (!ok) return '0;                                   // R8
    n = 2 << vl;
    if (st == 2'd0) r[511:128] = old[511:128];           // R7
    for (int j = 0; j < n; j++) begin
      longint x, y;
      x = longint'(int'(a[64*j +: 32]));
      y = (st == 2'd2 && bc && bm) ? longint'(int'(b[31:0])) : longint'(int'(b[64*j +: 32]));
      if (st == 2'd2 && me && !m[j])
        r[64*j +: 64] = zm ? 64'd0 : old[64*j +: 64];
      else
        r[64*j +: 64] = 64'(x * y);
    end
    return r;
  endfunction

  function automatic logic [511:0] mk(input int s);
    logic [511:0] v;
    for (int k = 0; k < 16; k++)
      v[32*k +: 32] = (32'(s) * 32'h41C64E6D) ^ (32'(k) * 32'h9E3779B9) ^ (32'h3039 * 32'(k + s + 1));
    return v;
  endfunction

  // driver: called at a negedge, drives one operation, returns at the next negedge
  task automatic op(input logic [511:0] a, b, old, input logic [7:0] m, input logic [1:0] st, vl,
                    input bit me, zm, bc, bm, input string tag, input bit push = 1'b1);
    src_a = a; src_b = b; old_dst = old; lane_mask = m; style = st; vlen = vl;
    mask_en = me; zero_mode = zm; bcast_en = bc; b_from_mem = bm; in_valid = 1'b1;
    if (push) begin
      exp_q.push_back(model(a, b, old, m, st, vl, me, zm, bc, bm));
      tag_q.push_back(tag);
      cyc_q.push_back(cyc);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !finished && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9/R10 unexpected out_valid", 512'(out_valid), 512'd0);
      end else begin
        logic [511:0] e;
        string t;
        int c;
        e = exp_q.pop_front(); t = tag_q.pop_front(); c = cyc_q.pop_front();
        chk(result == e, t, result, e);
        chk(cyc - c == 2, "R9 latency", 512'(cyc - c), 512'd2);
      end
    end
  end

  initial begin
    logic [511:0] ca, cb;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset state", 512'(out_valid), 512'd0);
    rst = 1'b0;

    // R2 corner values
    ca = mk(7); cb = mk(8);
    ca[31:0]    = 32'h80000000; cb[31:0]    = 32'h80000000;
    ca[95:64]   = 32'hFFFFFFFF; cb[95:64]   = 32'h00000001;
    ca[159:128] = 32'h7FFFFFFF; cb[159:128] = 32'h7FFFFFFF;
    ca[223:192] = 32'h80000000; cb[223:192] = 32'h7FFFFFFF;
    ca[287:256] = 32'h00000000; cb[287:256] = 32'h80000000;

    // back-to-back stream (R9)
    op(mk(1), mk(2), mk(3), 8'hFF, 2'd2, 2'd2, 0, 0, 0, 0, "R1 masked 512 no mask");
    op(ca, cb, mk(4), 8'h00, 2'd2, 2'd2, 0, 1, 0, 0, "R2 corner products, R4 mask off");
    op(mk(5), mk(6), mk(7), 8'hFF, 2'd2, 2'd0, 0, 0, 0, 0, "R3 masked 128");
    op(mk(8), mk(9), mk(10), 8'hFF, 2'd2, 2'd1, 0, 0, 0, 0, "R3 masked 256");
    op(mk(11), mk(12), mk(13), 8'hA5, 2'd2, 2'd2, 1, 0, 0, 0, "R4 merge mode");
    op(mk(14), mk(15), mk(16), 8'h5A, 2'd2, 2'd2, 1, 1, 0, 0, "R4 zero mode");
    op(mk(17), mk(18), mk(19), 8'h33, 2'd2, 2'd1, 1, 1, 0, 0, "R4 zero mode 256");
    op(mk(20), mk(21), mk(22), 8'hFF, 2'd2, 2'd2, 0, 0, 1, 1, "R5 broadcast");
    op(mk(23), mk(24), mk(25), 8'hFF, 2'd2, 2'd2, 0, 0, 1, 0, "R5 broadcast without memory");
    op(mk(26), mk(27), mk(28), 8'hFF, 2'd2, 2'd1, 1, 1, 1, 1, "R5 broadcast with mask 256");
    op(mk(29), mk(30), mk(31), 8'h00, 2'd1, 2'd0, 1, 1, 1, 1, "R6 plain 128 ignores mask");
    op(mk(32), mk(33), mk(34), 8'h00, 2'd1, 2'd1, 1, 0, 0, 0, "R6 plain 256");
    op(mk(35), mk(36), mk(37), 8'h00, 2'd0, 2'd0, 1, 1, 1, 1, "R7 legacy");
    op(ca, cb, mk(38), 8'hFF, 2'd0, 2'd0, 0, 0, 0, 0, "R7 legacy corner, R2");
    op(mk(39), mk(40), mk(41), 8'hFF, 2'd3, 2'd0, 0, 0, 0, 0, "R8 reserved style");
    op(mk(42), mk(43), mk(44), 8'hFF, 2'd2, 2'd3, 0, 0, 0, 0, "R8 reserved length");
    op(mk(45), mk(46), mk(47), 8'hFF, 2'd0, 2'd1, 0, 0, 0, 0, "R8 legacy 256");
    op(mk(48), mk(49), mk(50), 8'hFF, 2'd1, 2'd2, 0, 0, 0, 0, "R8 plain 512");

    // R1: upper halves changed, low halves equal, expected result identical
    ca = mk(60); cb = mk(61);
    for (int j = 0; j < 8; j++) begin
      ca[64*j+32 +: 32] = ~ca[64*j+32 +: 32];
      cb[64*j+32 +: 32] = 32'h0;
    end
    op(ca, cb, mk(62), 8'hFF, 2'd2, 2'd2, 0, 0, 0, 0, "R1 upper halves ignored");

    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle", 512'(out_valid), 512'd0);
    chk(exp_q.size() == 0, "R9 all results seen", 512'(exp_q.size()), 512'd0);

    // single isolated op for latency (R9)
    op(mk(70), mk(71), mk(72), 8'hFF, 2'd2, 2'd2, 0, 0, 0, 0, "R9 isolated");
    repeat (3) @(negedge clk);

    // R10: reset with an operation in flight discards it
    op(mk(80), mk(81), mk(82), 8'hFF, 2'd2, 2'd2, 0, 0, 0, 0, "R10 flushed", 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid == 1'b0, "R10 flush", 512'(out_valid), 512'd0);
      @(negedge clk);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule